// File: doc/BRIEF.md
# USB Frame Timing Counter

This block is the frame timebase of a USB host controller. It holds a software-written frame-interval register and a countdown of bit times in the current frame, and it keeps a 16-bit frame number. At every frame boundary it reloads the countdown, copies the software toggle into a readback toggle, advances the frame number and raises a one-cycle start-of-frame pulse. The low bits of the frame number are brought out as the index of the periodic list entry for the frame.

Counting is paced by an external bit-time enable, one pulse per 12 MHz bit time, so a default interval of 11999 gives a 1 ms frame. The countdown runs only while the host-controller state input is operational. Entering that state starts a fresh frame at once. Leaving it freezes the countdown, and the remaining-time readback then shows only the toggle. Software reads the interval, the remaining time, the frame number and a low-speed threshold register through a registered read port, and it writes through a single-cycle write port.

Top module: `usb_frame_timer`

## Requirements
- R1: Reset values apply. The interval read is 0x27782EDF: interval 11999 in bits 13:0, largest packet size 0x2778 in bits 30:16 and toggle 0 in bit 31. The threshold read is 0x00000628. The frame number is 0, and neither pulse output is active. `rd_data` gives the register picked by `rd_sel` one clock after the edge that samples it. The read selects are 0 for interval, 1 for remaining, 2 for frame number and 3 for threshold.
- R2: A write with select 0 loads the interval from bits 13:0, the packet size from bits 30:16 and the interval toggle from bit 31. Bits 15:14 read back as zero.
- R3: A write with select 3 loads the threshold from the low 12 data bits. The remaining bits read back as zero.
- R4: When `hc_state` changes to operational (2'b10), the next clock loads the countdown from the interval and the readback toggle from the interval toggle. It also raises `sof_pulse` for one cycle and leaves the frame number unchanged.
- R5: While operational, each `bit_en` cycle decrements a non-zero countdown. A `bit_en` cycle with a zero countdown is a frame boundary. A boundary reloads the interval, increments the frame number and raises `sof_pulse` for exactly one cycle, so a frame lasts interval+1 enabled cycles.
- R6: In the operational state the remaining readback carries the readback toggle in bit 31 and the countdown in bits 13:0. The toggle changes only at a boundary or on entry. A toggle written by software takes effect at the next boundary.
- R7: Outside the operational state the countdown and the frame number hold, and no `sof_pulse` occurs. The remaining readback returns the readback toggle in bit 31 and zero in all other bits.
- R8: The frame number wraps from 0xFFFF to 0x0000. `fno_pulse` is high for one cycle exactly when bit 15 of the frame number changes.
- R9: `periodic_idx` always equals bits 4:0 of the frame number.
- R10: Writes with select 1 (remaining) or select 2 (frame number) change neither the countdown nor the frame number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hc_state | input | 2 | Controller state: 0 reset, 1 resume, 2 operational, 3 suspend |
| bit_en | input | 1 | One pulse per bus bit time |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write register select |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read register select |
| rd_data | output | 32 | Registered read data |
| frame_num | output | 16 | Current frame number |
| periodic_idx | output | 5 | Periodic list entry for this frame |
| sof_pulse | output | 1 | Start-of-frame pulse |
| fno_pulse | output | 1 | Frame number bit 15 change pulse |

## Verification
The hardest situations to reach are the two frame-number wraps: the change of bit 15 at 0x7FFF→0x8000 and the full rollover at 0xFFFF→0x0000. At the default interval they are tens of seconds of bus time away. The stimulus programs an interval of zero, which makes every enabled cycle a boundary. It then holds the bit enable high, drops it one frame short of each wrap, and steps across the wrap with a single pulse. A second hard case is a frozen countdown, which cannot be read directly. It is exposed through a frozen frame number, an absent start-of-frame pulse and the toggle-only readback while suspended.

// File: rtl/usb_frame_pkg.sv
package usb_frame_pkg;
  typedef enum logic [1:0] {
    HC_RESET   = 2'd0,
    HC_RESUME  = 2'd1,
    HC_OPER    = 2'd2,
    HC_SUSPEND = 2'd3
  } hc_state_e;

  typedef enum logic [1:0] {
    SEL_INTERVAL = 2'd0,
    SEL_REMAIN   = 2'd1,
    SEL_FNUM     = 2'd2,
    SEL_LSTHR    = 2'd3
  } reg_sel_e;

  localparam int WORD_W   = 32;
  localparam int MPS_LSB  = 16;
  localparam int TOG_BIT  = 31;
endpackage

// File: rtl/usb_frame_regs.sv
module usb_frame_regs
  import usb_frame_pkg::*;
#(
  parameter int FI_W      = 14,
  parameter int MPS_W     = 15,
  parameter int LST_W     = 12,
  parameter int FI_RESET  = 11999,
  parameter int MPS_RESET = 'h2778,
  parameter int LST_RESET = 'h628
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  output logic [FI_W-1:0]   fi,
  output logic [MPS_W-1:0]  mps,
  output logic              fit,
  output logic [LST_W-1:0]  lst
);
  always_ff @(posedge clk) begin
    if (rst) begin
      fi  <= FI_W'(FI_RESET);
      mps <= MPS_W'(MPS_RESET);
      fit <= 1'b0;
      lst <= LST_W'(LST_RESET);
    end else if (wr_en) begin
      if (wr_sel == SEL_INTERVAL) begin
        fi  <= wr_data[FI_W-1:0];
        mps <= wr_data[MPS_LSB +: MPS_W];
        fit <= wr_data[TOG_BIT];
      end
      if (wr_sel == SEL_LSTHR) begin
        lst <= wr_data[LST_W-1:0];
      end
    end
  end
endmodule

// File: rtl/usb_frame_counter.sv
module usb_frame_counter #(
  parameter int FI_W = 14,
  parameter int FN_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            is_oper,
  input  logic            bit_en,
  input  logic [FI_W-1:0] fi,
  input  logic            fit,
  output logic [FI_W-1:0] rem_cnt,
  output logic            rem_tog,
  output logic [FN_W-1:0] fnum,
  output logic            sof,
  output logic            fno
);
  localparam logic [FN_W-1:0] FN_ONE = FN_W'(1);

  logic            oper_q;
  logic            entry;
  logic            boundary;
  logic [FN_W-1:0] fnum_nxt;

  assign entry    = is_oper && !oper_q;
  assign boundary = is_oper && oper_q && bit_en && (rem_cnt == '0);
  assign fnum_nxt = fnum + FN_ONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      oper_q  <= 1'b0;
      rem_cnt <= '0;
      rem_tog <= 1'b0;
      fnum    <= '0;
      sof     <= 1'b0;
      fno     <= 1'b0;
    end else begin
      oper_q <= is_oper;
      sof    <= 1'b0;
      fno    <= 1'b0;
      if (entry) begin
        rem_cnt <= fi;
        rem_tog <= fit;
        sof     <= 1'b1;
      end else if (boundary) begin
        rem_cnt <= fi;
        rem_tog <= fit;
        fnum    <= fnum_nxt;
        sof     <= 1'b1;
        fno     <= fnum_nxt[FN_W-1] ^ fnum[FN_W-1];
      end else if (is_oper && bit_en) begin
        rem_cnt <= rem_cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/usb_frame_rdmux.sv
module usb_frame_rdmux
  import usb_frame_pkg::*;
#(
  parameter int FI_W  = 14,
  parameter int MPS_W = 15,
  parameter int LST_W = 12,
  parameter int FN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        rd_sel,
  input  logic              is_oper,
  input  logic [FI_W-1:0]   fi,
  input  logic [MPS_W-1:0]  mps,
  input  logic              fit,
  input  logic [LST_W-1:0]  lst,
  input  logic [FI_W-1:0]   rem_cnt,
  input  logic              rem_tog,
  input  logic [FN_W-1:0]   fnum,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] word;

  always_comb begin
    word = '0;
    case (rd_sel)
      SEL_INTERVAL: begin
        word[FI_W-1:0]          = fi;
        word[MPS_LSB +: MPS_W]  = mps;
        word[TOG_BIT]           = fit;
      end
      SEL_REMAIN: begin
        word[TOG_BIT] = rem_tog;
        if (is_oper) word[FI_W-1:0] = rem_cnt;
      end
      SEL_FNUM:  word[FN_W-1:0]  = fnum;
      default:   word[LST_W-1:0] = lst;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= word;
  end
endmodule

// File: rtl/usb_frame_timer.sv
module usb_frame_timer
  import usb_frame_pkg::*;
#(
  parameter int FI_W      = 14,
  parameter int MPS_W     = 15,
  parameter int LST_W     = 12,
  parameter int FN_W      = 16,
  parameter int PIDX_W    = 5,
  parameter int FI_RESET  = 11999,
  parameter int MPS_RESET = 'h2778,
  parameter int LST_RESET = 'h628
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        hc_state,
  input  logic              bit_en,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [31:0]       wr_data,
  input  logic [1:0]        rd_sel,
  output logic [31:0]       rd_data,
  output logic [FN_W-1:0]   frame_num,
  output logic [PIDX_W-1:0] periodic_idx,
  output logic              sof_pulse,
  output logic              fno_pulse
);
  logic [FI_W-1:0]  fi;
  logic [MPS_W-1:0] mps;
  logic             fit;
  logic [LST_W-1:0] lst;
  logic [FI_W-1:0]  rem_cnt;
  logic             rem_tog;
  logic             is_oper;

  assign is_oper      = (hc_state == HC_OPER);
  assign periodic_idx = frame_num[PIDX_W-1:0];

  usb_frame_regs #(
    .FI_W(FI_W), .MPS_W(MPS_W), .LST_W(LST_W),
    .FI_RESET(FI_RESET), .MPS_RESET(MPS_RESET), .LST_RESET(LST_RESET)
  ) i_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .fi(fi), .mps(mps), .fit(fit), .lst(lst)
  );

  usb_frame_counter #(.FI_W(FI_W), .FN_W(FN_W)) i_cnt (
    .clk(clk), .rst(rst), .is_oper(is_oper), .bit_en(bit_en),
    .fi(fi), .fit(fit), .rem_cnt(rem_cnt), .rem_tog(rem_tog),
    .fnum(frame_num), .sof(sof_pulse), .fno(fno_pulse)
  );

  usb_frame_rdmux #(.FI_W(FI_W), .MPS_W(MPS_W), .LST_W(LST_W), .FN_W(FN_W)) i_rd (
    .clk(clk), .rst(rst), .rd_sel(rd_sel), .is_oper(is_oper),
    .fi(fi), .mps(mps), .fit(fit), .lst(lst),
    .rem_cnt(rem_cnt), .rem_tog(rem_tog), .fnum(frame_num), .rd_data(rd_data)
  );
endmodule

// File: rtl/usb_frame_timer_chk.sv
module usb_frame_timer_chk #(
  parameter int FI_W = 14,
  parameter int FN_W = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            is_oper,
  input logic [FI_W-1:0] rem_cnt,
  input logic [FN_W-1:0] frame_num,
  input logic            sof_pulse,
  input logic            fno_pulse,
  input logic [1:0]      rd_sel,
  input logic [31:0]     rd_data
);
  localparam logic [FN_W-1:0] STEP = FN_W'(1);

  AST_SOF_NEEDS_OPER: assert property (@(posedge clk) disable iff (rst)
    sof_pulse |-> $past(is_oper)); // R5

  AST_FROZEN_COUNT: assert property (@(posedge clk) disable iff (rst)
    !is_oper |=> $stable(rem_cnt)); // R7

  AST_FNUM_STEP: assert property (@(posedge clk) disable iff (rst)
    (frame_num != $past(frame_num)) |-> (frame_num == $past(frame_num) + STEP)); // R8

  AST_FNUM_WITH_SOF: assert property (@(posedge clk) disable iff (rst)
    (frame_num != $past(frame_num)) |-> sof_pulse); // R5

  AST_FNO_ON_MSB: assert property (@(posedge clk) disable iff (rst)
    fno_pulse |-> (frame_num[FN_W-1] != $past(frame_num[FN_W-1]))); // R8

  AST_IDLE_READ: assert property (@(posedge clk) disable iff (rst)
    (!is_oper && rd_sel == 2'd1) |=> (rd_data[30:0] == 31'd0)); // R7
endmodule

bind usb_frame_timer usb_frame_timer_chk #(.FI_W(FI_W), .FN_W(FN_W)) i_chk (
  .clk(clk), .rst(rst), .is_oper(is_oper), .rem_cnt(rem_cnt),
  .frame_num(frame_num), .sof_pulse(sof_pulse), .fno_pulse(fno_pulse),
  .rd_sel(rd_sel), .rd_data(rd_data)
);

// File: tb/test_usb_frame_timer.sv
`timescale 1ns/1ps
module test_usb_frame_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  hc_state = 2'd0;
  logic        bit_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = 2'd0;
  logic [31:0] rd_data;
  logic [15:0] frame_num;
  logic [4:0]  periodic_idx;
  logic        sof_pulse;
  logic        fno_pulse;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } sb_item_t;

  sb_item_t sb_q[$];
  int n_checks = 0;
  int n_errors = 0;
  int sof_total = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  usb_frame_timer i_usb_frame_timer (
    .clk(clk), .rst(rst), .hc_state(hc_state), .bit_en(bit_en),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .frame_num(frame_num), .periodic_idx(periodic_idx),
    .sof_pulse(sof_pulse), .fno_pulse(fno_pulse)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected read result one edge after the select
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sof_pulse === 1'b1) sof_total++;
      if (sb_q.size() > 0) begin
        sb_item_t it;
        it = sb_q.pop_front();
        chk(rd_data, it.exp, it.tag);
      end
    end
  end

  task automatic rd(input logic [1:0] sel, input logic [31:0] exp, input string tag);
    sb_item_t it;
    @(negedge clk);
    rd_sel = sel;
    it.exp = exp;
    it.tag = tag;
    sb_q.push_back(it);
    @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input int n);
    @(negedge clk);
    bit_en = 1'b1;
    repeat (n) @(negedge clk);
    bit_en = 1'b0;
  endtask

  task automatic run_to(input logic [15:0] target);
    @(negedge clk);
    bit_en = 1'b1;
    for (int i = 0; i < 70000 && frame_num != target; i++) @(negedge clk);
    bit_en = 1'b0;
  endtask

  initial begin
    int sof_snap;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk({31'd0, sof_pulse}, 32'd0, "R1 sof after reset");
    chk({16'd0, frame_num}, 32'd0, "R1 frame number after reset");
    rd(2'd0, 32'h27782EDF, "R1 interval reset");
    rd(2'd3, 32'h00000628, "R1 threshold reset");
    rd(2'd2, 32'h00000000, "R1 frame number read");
    rd(2'd1, 32'h00000000, "R1 remaining read idle");

    wr(2'd0, 32'hFFFFFFFF);
    rd(2'd0, 32'hFFFF3FFF, "R2 interval all ones");
    wr(2'd3, 32'hFFFFF123);
    rd(2'd3, 32'h00000123, "R3 threshold masked");
    wr(2'd0, 32'h80000004);
    rd(2'd0, 32'h80000004, "R2 interval fields");

    @(negedge clk);
    hc_state = 2'd2;
    @(negedge clk);
    chk({31'd0, sof_pulse}, 32'd1, "R4 sof on entry");
    chk({16'd0, frame_num}, 32'd0, "R4 frame number held on entry");
    @(negedge clk);
    chk({31'd0, sof_pulse}, 32'd0, "R5 sof one cycle");
    rd(2'd1, 32'h80000004, "R4 reload on entry");

    pulse(3);
    rd(2'd1, 32'h80000001, "R5 decrement");
    wr(2'd0, 32'h00000004);
    pulse(1);
    chk({31'd0, sof_pulse}, 32'd0, "R5 no sof before boundary");
    rd(2'd1, 32'h80000000, "R6 toggle waits for boundary");
    pulse(1);
    chk({31'd0, sof_pulse}, 32'd1, "R5 sof at boundary");
    chk({16'd0, frame_num}, 32'd1, "R5 frame number increments");
    rd(2'd1, 32'h00000004, "R6 toggle reloaded");

    wr(2'd0, 32'h80000004);
    pulse(5);
    chk({16'd0, frame_num}, 32'd2, "R5 frame length interval+1");
    rd(2'd1, 32'h80000004, "R6 toggle set at boundary");
    pulse(2);

    wr(2'd1, 32'h00000000);
    wr(2'd2, 32'h0000FFFF);
    rd(2'd1, 32'h80000002, "R10 remaining write ignored");
    rd(2'd2, 32'h00000002, "R10 frame number write ignored");

    @(negedge clk);
    hc_state = 2'd3;
    sof_snap = sof_total;
    pulse(6);
    rd(2'd1, 32'h80000000, "R7 toggle only when idle");
    chk({16'd0, frame_num}, 32'd2, "R7 frame number frozen");
    chk(sof_total, sof_snap, "R7 no sof when idle");

    @(negedge clk);
    hc_state = 2'd2;
    rd(2'd1, 32'h80000004, "R4 re-entry reload");
    chk({16'd0, frame_num}, 32'd2, "R4 frame number after re-entry");

    wr(2'd0, 32'h00000000);
    run_to(16'h7FFF);
    chk({31'd0, fno_pulse}, 32'd0, "R8 no fno below msb change");
    chk({27'd0, periodic_idx}, 32'd31, "R9 periodic index 31");
    pulse(1);
    chk({16'd0, frame_num}, 32'h8000, "R8 frame 0x8000");
    chk({31'd0, fno_pulse}, 32'd1, "R8 fno at msb set");
    chk({27'd0, periodic_idx}, 32'd0, "R9 periodic index 0");
    @(negedge clk);
    chk({31'd0, fno_pulse}, 32'd0, "R8 fno one cycle");
    run_to(16'hFFFF);
    pulse(1);
    chk({16'd0, frame_num}, 32'd0, "R8 wrap to zero");
    chk({31'd0, fno_pulse}, 32'd1, "R8 fno at wrap");
    chk({31'd0, sof_pulse}, 32'd1, "R5 sof at wrap");
    rd(2'd1, 32'h00000000, "R6 zero interval readback");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(20 * 190000);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL R5 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule